// File: doc/BRIEF.md
# I2C Target with Acknowledge Policy

This block is the target side of a two-wire serial bus. It oversamples the clock and data lines with the system clock, cleans them with a synchronizer and a majority filter, and detects START, repeated START and STOP. After a START it collects a 7-bit address and a direction bit. On a write, the first data byte is a command code that is looked up in a parameter table, and the following bytes land in a small register file. On a read, it shifts register contents out MSB first. Both lines are open-drain: the block only asserts an output enable that pulls the line low.

Each acknowledge slot that belongs to the target is settled by an explicit policy. It answers ACK when the address is its own, the command is known and there is room for the byte. It answers NACK when the address belongs to another device, when the application raises `busy_i`, when the command is unknown, or when the byte would run past the last register. A NACK from the controller during a read ends the transfer. Short waits never produce a NACK: when `delay_i` is high at the end of a target ACK slot, the block holds SCL low until `ready_i` pulses. A timeout counter bounds that hold.

The control state machine has seven states:
- IDLE: waits for START.
- RX: shifts in an address or write byte.
- ACK: the target drives ACK.
- TX: shifts a read byte out.
- HACK: samples the controller's acknowledge.
- HOLD: clock stretch.
- SKIP: silent until the next START or STOP.

Its transitions are:
- IDLE→RX on START.
- RX→ACK when a byte is accepted; RX→SKIP when it is refused.
- ACK→HOLD on the falling edge that closes the slot if `delay_i` is high; otherwise ACK→TX (read) or ACK→RX (write).
- HOLD→TX or HOLD→RX when the hold ends.
- TX→HACK after 8 bits.
- HACK→TX on a controller ACK; HACK→SKIP on a controller NACK.
- From any state, START goes to RX and STOP goes to IDLE.

Top module: `i2c_ack_target`

## Requirements
- R1: An address byte whose upper 7 bits equal the configured address (default 0x2A) gets ACK, meaning SDA is pulled low during the 9th SCL pulse. Bit 0 selects the direction: 0 for write, 1 for read.
- R2: An address byte that does not match is left unacknowledged (SDA released). Every later byte up to the next START or STOP also gets no ACK.
- R3: While `busy_i` is high at the end of the address byte, the target answers even its own address with NACK.
- R4: The first byte after a write address is a command code. The codes 0x10, 0x20, 0x30 and 0x40 are known and select registers 0 to 3 as the pointer. Any other code gets NACK, and the rest of the transfer is ignored.
- R5: Each write data byte that is accepted gets ACK. It is stored at the pointer, and the pointer then advances by one.
- R6: A write data byte that arrives when the pointer is already past register 3 gets NACK and is not stored.
- R7: A read sends the register at the pointer, MSB first. A controller ACK advances the pointer (3 wraps to 0) and the next register follows. After a controller NACK the target leaves SDA released until START or STOP, and the pointer does not advance.
- R8: A repeated START at any bit position, including mid-byte, returns the target to address reception.
- R9: The target changes its SDA output only while SCL is low.
- R10: If `delay_i` is high at the SCL falling edge that closes a target ACK slot, SCL is held low until a one-cycle `ready_i` pulse. The ACK already given stays an ACK.
- R11: A clock stretch that lasts TMO_CYC (default 200) system clocks without `ready_i` releases SCL and pulses `stretch_err_o` for one cycle.
- R12: After reset both line enables are low and `stretch_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| busy_i | input | 1 | Application busy; forces NACK of own address |
| delay_i | input | 1 | Request a clock stretch after the current target ACK slot |
| ready_i | input | 1 | One-cycle strobe ending a clock stretch |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (ACK or a 0 data bit) |
| stretch_err_o | output | 1 | One-cycle pulse when a stretch times out |

## Verification
The hardest situations to reach are a repeated START that lands in the middle of a byte, and a stretch that has to be observed from the controller side while the controller is itself trying to raise SCL. The bench bit-bangs the bus as a controller using wired-AND line models. It cuts a write byte after three bits to issue the repeated START. For the stretch cases, a forked watcher runs beside the transfer: it sees the hold begin, then either supplies the `ready_i` strobe late or withholds it, which forces the timeout path.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_HACK,
        ST_HOLD,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_ack_filt.sv
module i2c_ack_filt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic       s1, s2, lvl, maj;
        logic [2:0] hist;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1   <= 1'b1;
                s2   <= 1'b1;
                hist <= 3'b111;
                lvl  <= 1'b1;
            end else begin
                s1   <= raw_i[g];
                s2   <= s1;
                hist <= {hist[1:0], s2};
                lvl  <= maj;
            end
        end

        assign maj       = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);
        assign lvl_o[g]  = lvl;
        assign rise_o[g] = maj & ~lvl;
        assign fall_o[g] = ~maj & lvl;
    end
endmodule

// File: rtl/i2c_ack_cmdmatch.sv
module i2c_ack_cmdmatch #(
    parameter int              NCMD  = 4,
    parameter int              IW    = 2,
    parameter logic [NCMD*8-1:0] TABLE = {8'h40, 8'h30, 8'h20, 8'h10}
) (
    input  logic [7:0]    code_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    logic [NCMD-1:0] hits;

    for (genvar g = 0; g < NCMD; g++) begin : g_cmp
        assign hits[g] = (code_i == TABLE[g*8 +: 8]);
    end

    always_comb begin
        idx_o = '0;
        for (int i = NCMD - 1; i >= 0; i--) begin
            if (hits[i]) idx_o = IW'(i);
        end
    end

    assign hit_o = |hits;
endmodule

// File: rtl/i2c_ack_stretch.sv
module i2c_ack_stretch #(
    parameter int TMO_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic ready_i,
    output logic hold_o,
    output logic tmo_o
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o <= 1'b0;
            tmo_o  <= 1'b0;
            cnt    <= '0;
        end else begin
            tmo_o <= 1'b0;
            if (arm_i) begin
                hold_o <= 1'b1;
                cnt    <= '0;
            end else if (hold_o) begin
                if (ready_i) begin
                    hold_o <= 1'b0;
                end else if (cnt == CW'(TMO_CYC - 1)) begin
                    hold_o <= 1'b0;
                    tmo_o  <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R11: the counter never passes its limit while holding
    p_hold_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> (cnt < CW'(TMO_CYC)));
    // R11: a timeout pulse always comes with SCL released
    p_tmo_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> !hold_o);
endmodule

// File: rtl/i2c_ack_target.sv
module i2c_ack_target
    import i2c_ack_pkg::*;
#(
    parameter logic [6:0]        OWN_ADDR  = 7'h2A,
    parameter int                NREG      = 4,
    parameter logic [NREG*8-1:0] CMD_TABLE = {8'h40, 8'h30, 8'h20, 8'h10},
    parameter int                TMO_CYC   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic busy_i,
    input  logic delay_i,
    input  logic ready_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic stretch_err_o
);
    localparam int PW = $clog2(NREG);

    tgt_state_e state, nstate;

    logic [1:0]    lvl, rise, fall;
    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic [3:0]    cnt;
    logic [7:0]    shreg, txsh;
    logic          is_addr, is_cmd, rd_q, host_nack, sda_oe_q;
    logic [PW:0]   ptr;
    logic [PW-1:0] idx, idx_nxt, cmd_idx;
    logic          cmd_hit, room, rx_ack, byte_done, arm, scl_hold;
    logic [7:0]    regs [NREG];

    i2c_ack_filt #(.W(2)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    i2c_ack_cmdmatch #(.NCMD(NREG), .IW(PW), .TABLE(CMD_TABLE)) u_cmd (
        .code_i(shreg), .hit_o(cmd_hit), .idx_o(cmd_idx)
    );

    i2c_ack_stretch #(.TMO_CYC(TMO_CYC)) u_str (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .ready_i(ready_i),
        .hold_o(scl_hold), .tmo_o(stretch_err_o)
    );

    assign scl_lvl   = lvl[1];
    assign sda_lvl   = lvl[0];
    assign scl_rise  = rise[1];
    assign scl_fall  = fall[1];
    assign start_ev  = fall[0] & scl_lvl;
    assign stop_ev   = rise[0] & scl_lvl;

    assign idx       = ptr[PW-1:0];
    assign idx_nxt   = PW'(idx + 1'b1);
    assign room      = (ptr < (PW+1)'(NREG));
    assign byte_done = (state == ST_RX) && scl_fall && (cnt == 4'd8);
    assign rx_ack    = is_addr ? ((shreg[7:1] == OWN_ADDR) && !busy_i)
                     : is_cmd  ? cmd_hit
                     : room;
    assign arm       = (state == ST_ACK) && scl_fall && delay_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        if (start_ev) begin
            nstate = ST_RX;
        end else if (stop_ev) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nstate = ST_IDLE;
                ST_RX:   if (byte_done) nstate = rx_ack ? ST_ACK : ST_SKIP;
                ST_ACK:  if (scl_fall)  nstate = delay_i ? ST_HOLD : (rd_q ? ST_TX : ST_RX);
                ST_HOLD: if (!scl_hold) nstate = rd_q ? ST_TX : ST_RX;
                ST_TX:   if (scl_fall && cnt == 4'd8) nstate = ST_HACK;
                ST_HACK: if (scl_fall)  nstate = host_nack ? ST_SKIP : ST_TX;
                ST_SKIP: nstate = ST_SKIP;
            endcase
        end
    end

    // datapath and line outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            txsh      <= '0;
            is_addr   <= 1'b1;
            is_cmd    <= 1'b0;
            rd_q      <= 1'b0;
            host_nack <= 1'b0;
            ptr       <= '0;
            sda_oe_q  <= 1'b0;
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (start_ev) begin
            cnt      <= '0;
            is_addr  <= 1'b1;
            is_cmd   <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (stop_ev) begin
            sda_oe_q <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                    end
                    if (byte_done) begin
                        sda_oe_q <= rx_ack;
                        if (is_addr) begin
                            rd_q    <= shreg[0];
                            is_addr <= 1'b0;
                            is_cmd  <= !shreg[0];
                        end else if (is_cmd) begin
                            is_cmd <= 1'b0;
                            if (cmd_hit) ptr <= {1'b0, cmd_idx};
                        end else if (room) begin
                            regs[idx] <= shreg;
                            ptr       <= ptr + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rd_q) begin
                            txsh     <= regs[idx];
                            sda_oe_q <= ~regs[idx][7];
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) cnt <= cnt + 1'b1;
                    if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            sda_oe_q <= 1'b0;
                        end else begin
                            txsh     <= {txsh[6:0], 1'b0};
                            sda_oe_q <= ~txsh[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) host_nack <= sda_lvl;
                    if (scl_fall && !host_nack) begin
                        cnt      <= '0;
                        ptr      <= {1'b0, idx_nxt};
                        txsh     <= regs[idx_nxt];
                        sda_oe_q <= ~regs[idx_nxt][7];
                    end
                end
                ST_IDLE, ST_HOLD, ST_SKIP: begin
                end
            endcase
        end
    end

    assign scl_oe_o = scl_hold;
    assign sda_oe_o = sda_oe_q;

    // R9: SDA drive only moves while the filtered SCL is low
    p_sda_low_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> !scl_lvl);
    // R3: a busy application refuses its own address
    p_busy_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && is_addr && busy_i) |=> !sda_oe_q);
    // R2: a refused transfer stays silent on both lines
    p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_oe_q && !scl_oe_o));
    // R6: no acknowledge once the register file is exhausted
    p_no_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !is_addr && !is_cmd && !room) |=> !sda_oe_q);
    // R10: stretching begins only with SCL already low
    p_hold_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> !scl_lvl);
endmodule

// File: tb/i2c_ack_target_test.sv
module i2c_ack_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 20;
    localparam int TMO        = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic busy = 1'b0, dly = 1'b0, rdy = 1'b0;
    logic scl_oe, sda_oe, serr;
    logic scl_w, sda_w;

    assign scl_w = m_scl & ~scl_oe;
    assign sda_w = m_sda & ~sda_oe;

    i2c_ack_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
        .busy_i(busy), .delay_i(dly), .ready_i(rdy),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .stretch_err_o(serr)
    );

    int checks = 0, errors = 0;
    logic [7:0] mregs [4];
    int mptr = 0;
    bit tmo_window = 1'b0;
    logic prev_sda_oe = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model of the register file and pointer
    function automatic bit mdl_cmd(input logic [7:0] c);
        if (c == 8'h10 || c == 8'h20 || c == 8'h30 || c == 8'h40) begin
            mptr = int'(c[7:4]) - 1;
            return 1'b1;
        end
        return 1'b0;
    endfunction
    function automatic bit mdl_data(input logic [7:0] d);
        if (mptr < 4) begin
            mregs[mptr] = d;
            mptr++;
            return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic scl_up();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_w) @(negedge clk);
    endtask
    task automatic bit_out(input bit b);
        m_sda = b; wclk(H/2); scl_up(); wclk(H); m_scl = 1'b0; wclk(H/2);
    endtask
    task automatic bit_in(output bit b);
        m_sda = 1'b1; wclk(H/2); scl_up(); wclk(H/2); b = sda_w; wclk(H/2);
        m_scl = 1'b0; wclk(H/2);
    endtask
    task automatic start();
        m_sda = 1'b1; wclk(H/2); scl_up(); wclk(H); m_sda = 1'b0; wclk(H);
        m_scl = 1'b0; wclk(H/2);
    endtask
    task automatic stop();
        m_sda = 1'b0; wclk(H/2); scl_up(); wclk(H); m_sda = 1'b1; wclk(H);
    endtask
    task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        check(!a == exp_ack, req, int'(!a), int'(exp_ack));
    endtask
    task automatic recv(input bit host_ack, input string req);
        logic [7:0] d;
        logic [7:0] exp;
        bit b;
        exp = mregs[mptr % 4];
        for (int i = 0; i < 8; i++) begin
            bit_in(b);
            d = {d[6:0], b};
        end
        bit_out(!host_ack);
        check(d == exp, req, int'(d), int'(exp));
        if (host_ack) mptr = (mptr % 4 + 1) % 4;
    endtask

    // per-clock monitors: R9 and stray timeout pulses (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_sda_oe) check(!scl_w, "R9 SDA drive changed with SCL high", int'(scl_w), 0);
            if (serr && !tmo_window) check(1'b0, "R11 unexpected timeout pulse", 1, 0);
        end
        prev_sda_oe = sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit b;
        for (int i = 0; i < 4; i++) mregs[i] = 8'h00;
        wclk(5);
        check(scl_oe == 1'b0, "R12 scl enable in reset", int'(scl_oe), 0);
        check(sda_oe == 1'b0, "R12 sda enable in reset", int'(sda_oe), 0);
        check(serr == 1'b0, "R12 error flag in reset", int'(serr), 0);
        rst_n = 1'b1;
        wclk(10);

        // plain write
        start();
        send(8'h54, 1'b1, "R1 own address write");
        send(8'h20, mdl_cmd(8'h20), "R4 known command");
        send(8'hA1, mdl_data(8'hA1), "R5 data byte 1");
        send(8'hB2, mdl_data(8'hB2), "R5 data byte 2");
        stop();

        // read back through a repeated START at a byte boundary
        start();
        send(8'h54, 1'b1, "R1 own address");
        send(8'h20, mdl_cmd(8'h20), "R4 command before read");
        start();
        send(8'h55, 1'b1, "R8 address read after repeated START");
        recv(1'b1, "R7 read first register");
        recv(1'b0, "R7 read second register");
        bit_in(b);
        check(b == 1'b1, "R7 silent after controller NACK", int'(b), 1);
        stop();

        // unknown command
        start();
        send(8'h54, 1'b1, "R1 own address");
        send(8'h55, mdl_cmd(8'h55), "R4 unknown command NACK");
        send(8'h00, 1'b0, "R4 rest of transfer ignored");
        stop();

        // no room past the last register
        start();
        send(8'h54, 1'b1, "R1 own address");
        send(8'h40, mdl_cmd(8'h40), "R4 last register command");
        send(8'h7E, mdl_data(8'h7E), "R5 store last register");
        send(8'h11, mdl_data(8'h11), "R6 no room NACK");
        stop();
        start();
        send(8'h54, 1'b1, "R1 own address");
        send(8'h40, mdl_cmd(8'h40), "R4 command");
        start();
        send(8'h55, 1'b1, "R8 read address");
        recv(1'b0, "R6 last register untouched by refused byte");
        stop();

        // foreign address
        start();
        send(8'h66, 1'b0, "R2 foreign address NACK");
        send(8'h20, 1'b0, "R2 following byte ignored");
        stop();

        // busy application
        busy = 1'b1;
        start();
        send(8'h54, 1'b0, "R3 busy NACK of own address");
        stop();
        busy = 1'b0;

        // repeated START in the middle of a byte
        start();
        send(8'h54, 1'b1, "R1 own address");
        send(8'h10, mdl_cmd(8'h10), "R4 first register command");
        send(8'h5C, mdl_data(8'h5C), "R5 store register 0");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        start();
        send(8'h55, 1'b1, "R8 address after mid-byte repeated START");
        recv(1'b0, "R8 read after mid-byte restart");
        stop();

        // clock stretch released by ready
        dly = 1'b1;
        fork
            begin
                start();
                send(8'h54, 1'b1, "R10 address acked, not NACKed");
                send(8'h30, mdl_cmd(8'h30), "R10 command after stretch");
                send(8'h99, mdl_data(8'h99), "R5 data after stretch");
                stop();
            end
            begin
                int held;
                held = 0;
                while (!scl_oe) @(negedge clk);
                dly = 1'b0;
                repeat (60) begin
                    @(negedge clk);
                    if (scl_oe && !scl_w) held++;
                end
                check(held == 60, "R10 SCL held until ready", held, 60);
                rdy = 1'b1; @(negedge clk); rdy = 1'b0; @(negedge clk);
                check(scl_oe == 1'b0, "R10 SCL released after ready", int'(scl_oe), 0);
            end
        join

        // clock stretch ended by timeout
        dly = 1'b1;
        tmo_window = 1'b1;
        fork
            begin
                start();
                send(8'h54, 1'b1, "R11 address acked before stretch");
                send(8'h20, mdl_cmd(8'h20), "R11 transfer resumes after timeout");
                stop();
            end
            begin
                int n;
                n = 0;
                while (!scl_oe) @(negedge clk);
                dly = 1'b0;
                while (!serr && n < 1000) begin
                    @(negedge clk);
                    n++;
                end
                check(serr == 1'b1, "R11 timeout pulse seen", int'(serr), 1);
                check(n >= TMO - 3 && n <= TMO + 3, "R11 timeout length", n, TMO);
                @(negedge clk);
                check(scl_oe == 1'b0, "R11 SCL released on timeout", int'(scl_oe), 0);
                check(serr == 1'b0, "R11 timeout pulse one cycle", int'(serr), 0);
            end
        join
        tmo_window = 1'b0;
        wclk(20);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule